// File: doc/BRIEF.md
# Dual-Rail Four-Phase Pipeline Register

This block is one stage of a dual-rail, delay-insensitive pipeline. Every data bit travels on two rails: the true rail high means logic 1, the false rail high means logic 0, and both rails low means the bit is empty (NULL). Waves alternate: a DATA wave fills every bit, then a NULL wave empties every bit. Each output rail is the state of a two-input hysteresis gate. One gate input is the matching input rail. The other is the request level returned by the next stage. The gate rises only when both inputs are high, falls only when both are low, and otherwise keeps its value.

A completion detector watches the register outputs and drives the request sent back to the previous stage. That request is low (asking for NULL) once every output bit holds DATA. It is high (asking for DATA) once every output bit is empty. For any mix of the two it does not move. A stage therefore cycles through four phases in a fixed order: take in NULL, ask for DATA, take in DATA, ask for NULL. Stages can be chained directly, each stage's request output wired to the upstream neighbour's request input.

All hysteresis state is held in flip-flops that update on an evaluation tick `clk`. This gives a discrete-time model of the threshold gates that standard synchronous tools can handle. The tick is not a pipeline clock: whether a stage advances depends only on the handshake levels. The detector comes in two variants. The flat variant is one threshold gate over all bits. The grouped variant is a two-level tree of threshold gates.

Top module: `ncl_hs_reg`

## Requirements
- R1: While `rst_n` is low, every output rail is cleared to 0 (all bits NULL) and `to_prev` is 1 (requesting DATA).
- R2: An output rail becomes 1 on the tick after both its input rail and `from_next` are 1. Input bit value 1 is `in_t`=1, `in_f`=0, and value 0 is `in_t`=0, `in_f`=1.
- R3: An output rail becomes 0 on the tick after both its input rail and `from_next` are 0.
- R4: While an input rail and `from_next` disagree, that output rail keeps its value. In particular, DATA presented while `from_next` is 0 is not taken in, and NULL presented while `from_next` is 1 does not clear the outputs.
- R5: In the flat variant, `to_prev` goes to 0 on the tick after every output bit holds DATA. While only some bits hold DATA it stays 1.
- R6: In the flat variant, `to_prev` goes to 1 on the tick after every output bit is NULL. While only some bits are NULL it stays 0.
- R7: If the upstream neighbour keeps the protocol, an output bit never moves directly from one DATA value to the other and never shows both rails high. A NULL always separates successive DATA values.
- R8: In a chain of stages with arbitrary handshake delays at both ends, every DATA token comes out unchanged and in the order it went in.
- R9: In the grouped variant (`CMP_STYLE`=CMP_GROUPED), `to_prev` changes one tick later than in the flat variant. A group that is complete on its own does not move `to_prev` while another group disagrees. `WIDTH` must be a multiple of `GROUP`, and this is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation tick for the hysteresis state |
| rst_n | input | 1 | Active-low asynchronous reset to the empty state |
| in_t | input | WIDTH | True rails from the upstream logic |
| in_f | input | WIDTH | False rails from the upstream logic |
| from_next | input | 1 | Request from the downstream stage: 1 asks for DATA, 0 asks for NULL |
| out_t | output | WIDTH | Registered true rails |
| out_f | output | WIDTH | Registered false rails |
| to_prev | output | 1 | Request to the upstream stage: inverse of word completion |

## Verification
The in-module assertions check three things on every tick. First, each rail rises, falls or holds according to its two gate inputs. Second, each completion gate moves only when all of its inputs agree. Third, no output bit swaps directly between DATA values. Together these cover R2 to R7 at the level of single gates. Behaviour at the word and chain level can only be shown by the bench's scenarios. These include partial waves that must leave the request unchanged, the extra tick of latency in the grouped variant, and an ordered, unaltered token stream through three chained stages with random producer and consumer delays.

// File: rtl/ncl_pkg.sv
package ncl_pkg;

   // Completion detector structure.
   typedef enum logic {
      CMP_FLAT    = 1'b0,
      CMP_GROUPED = 1'b1
   } cmp_style_e;

   // Next state of a hysteresis (threshold) element: set wins when all
   // inputs are high, clear when all are low, otherwise hold.
   function automatic logic hyst_next(input logic set_c,
                                      input logic clr_c,
                                      input logic cur);
      logic nxt;
      if (set_c)      nxt = 1'b1;
      else if (clr_c) nxt = 1'b0;
      else            nxt = cur;
      return nxt;
   endfunction

endpackage

// File: rtl/ncl_th22_bank.sv
module ncl_th22_bank #(
   parameter int unsigned NRAIL = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NRAIL-1:0] rail_in,
   input  logic             gate_in,
   output logic [NRAIL-1:0] rail_q
);

   generate
      if (NRAIL < 1) begin : g_bad_nrail
         $error("ncl_th22_bank: NRAIL must be at least 1");
      end
   endgenerate

   generate
      for (genvar i = 0; i < NRAIL; i++) begin : g_gate
         logic both_hi;
         logic both_lo;
         assign both_hi = rail_in[i] & gate_in;
         assign both_lo = ~rail_in[i] & ~gate_in;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rail_q[i] <= 1'b0;
            else        rail_q[i] <= ncl_pkg::hyst_next(both_hi, both_lo, rail_q[i]);
         end

         // R2: rail and request both high -> rail high next tick
         a_r2_rise_on_both: assert property (@(posedge clk) disable iff (!rst_n)
            (rail_in[i] && gate_in) |=> rail_q[i]);
         // R3: rail and request both low -> rail low next tick
         a_r3_fall_on_both: assert property (@(posedge clk) disable iff (!rst_n)
            (!rail_in[i] && !gate_in) |=> !rail_q[i]);
         // R4: disagreeing inputs leave the rail untouched
         a_r4_hold_on_mixed: assert property (@(posedge clk) disable iff (!rst_n)
            (rail_in[i] != gate_in) |=> $stable(rail_q[i]));
      end
   endgenerate

endmodule

// File: rtl/ncl_cgate.sv
module ncl_cgate #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cin,
   output logic         cout
);

   generate
      if (N < 1) begin : g_bad_n
         $error("ncl_cgate: N must be at least 1");
      end
   endgenerate

   logic all_hi;
   logic all_lo;
   assign all_hi = &cin;
   assign all_lo = ~|cin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cout <= 1'b0;
      else        cout <= ncl_pkg::hyst_next(all_hi, all_lo, cout);
   end

   // R5: completion only asserts after every input reported
   a_r5_set_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cout) |-> $past(cin == {N{1'b1}}));
   // R6: completion only clears after every input emptied
   a_r6_clear_needs_none: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cout) |-> $past(cin == {N{1'b0}}));
   // R5 / R6: a mixed input set never moves the output
   a_r6_hold_on_mixed: assert property (@(posedge clk) disable iff (!rst_n)
      (cin != {N{1'b0}} && cin != {N{1'b1}}) |=> $stable(cout));

endmodule

// File: rtl/ncl_completion.sv
module ncl_completion #(
   parameter int unsigned         WIDTH     = 8,
   parameter ncl_pkg::cmp_style_e CMP_STYLE = ncl_pkg::CMP_FLAT,
   parameter int unsigned         GROUP     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] rail_t,
   input  logic [WIDTH-1:0] rail_f,
   output logic             done
);

   localparam int unsigned NGRP = (GROUP == 0) ? 1 : (WIDTH / GROUP);

   logic [WIDTH-1:0] bit_full;
   assign bit_full = rail_t | rail_f;

   generate
      if (CMP_STYLE == ncl_pkg::CMP_FLAT) begin : g_flat
         ncl_cgate #(.N(WIDTH)) u_word (
            .clk  (clk),
            .rst_n(rst_n),
            .cin  (bit_full),
            .cout (done)
         );
      end else begin : g_grouped
         if (GROUP < 1 || (WIDTH % GROUP) != 0) begin : g_bad_group
            $error("ncl_completion: WIDTH must be a non-zero multiple of GROUP");
         end
         logic [NGRP-1:0] grp_done;
         for (genvar g = 0; g < NGRP; g++) begin : g_grp
            ncl_cgate #(.N(GROUP)) u_grp (
               .clk  (clk),
               .rst_n(rst_n),
               .cin  (bit_full[g*GROUP +: GROUP]),
               .cout (grp_done[g])
            );
         end
         ncl_cgate #(.N(NGRP)) u_word (
            .clk  (clk),
            .rst_n(rst_n),
            .cin  (grp_done),
            .cout (done)
         );
      end
   endgenerate

endmodule

// File: rtl/ncl_hs_reg.sv
module ncl_hs_reg #(
   parameter int unsigned         WIDTH     = 8,
   parameter ncl_pkg::cmp_style_e CMP_STYLE = ncl_pkg::CMP_FLAT,
   parameter int unsigned         GROUP     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] in_t,
   input  logic [WIDTH-1:0] in_f,
   input  logic             from_next,
   output logic [WIDTH-1:0] out_t,
   output logic [WIDTH-1:0] out_f,
   output logic             to_prev
);

   localparam int unsigned NRAIL = 2 * WIDTH;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ncl_hs_reg: WIDTH must be at least 1");
      end
   endgenerate

   // One bank gates both rail sets against the downstream request.
   logic [NRAIL-1:0] rails_in;
   logic [NRAIL-1:0] rails_q;
   assign rails_in = {in_f, in_t};

   ncl_th22_bank #(.NRAIL(NRAIL)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .rail_in(rails_in),
      .gate_in(from_next),
      .rail_q (rails_q)
   );

   assign out_t = rails_q[WIDTH-1:0];
   assign out_f = rails_q[NRAIL-1:WIDTH];

   logic word_done;

   ncl_completion #(
      .WIDTH    (WIDTH),
      .CMP_STYLE(CMP_STYLE),
      .GROUP    (GROUP)
   ) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .rail_t(out_t),
      .rail_f(out_f),
      .done  (word_done)
   );

   assign to_prev = ~word_done;

   // R1: reset empties the stage and requests DATA
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (out_t == '0 && out_f == '0 && to_prev));

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_chk
         // R7: a true-valued bit never turns into a false-valued one directly
         a_r7_no_swap_t: assert property (@(posedge clk) disable iff (!rst_n)
            out_t[i] |=> !out_f[i]);
         // R7: and the reverse
         a_r7_no_swap_f: assert property (@(posedge clk) disable iff (!rst_n)
            out_f[i] |=> !out_t[i]);
      end
   endgenerate

endmodule

// File: tb/ncl_hs_reg_tb.sv
module ncl_hs_reg_tb;

   localparam int W    = 8;
   localparam int NTOK = 12;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic         rst_n;
   logic [W-1:0] in_t, in_f;
   logic         from_next;
   logic [W-1:0] d_out_t, d_out_f, g_out_t, g_out_f;
   logic         d_req, g_req;

   int checks   = 0;
   int failures = 0;

   ncl_hs_reg #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .from_next(from_next),
      .out_t(d_out_t), .out_f(d_out_f), .to_prev(d_req));

   ncl_hs_reg #(.WIDTH(W), .CMP_STYLE(ncl_pkg::CMP_GROUPED), .GROUP(4)) u_grp (
      .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .from_next(from_next),
      .out_t(g_out_t), .out_f(g_out_f), .to_prev(g_req));

   // Three-stage chain
   logic [W-1:0] c0_t, c0_f, c1_t, c1_f, c2_t, c2_f, c3_t, c3_f;
   logic         r0, r1, r2, c_fn;
   logic         chain_on = 1'b0;
   int           swaps = 0;

   ncl_hs_reg #(.WIDTH(W)) u_s0 (.clk(clk), .rst_n(rst_n), .in_t(c0_t), .in_f(c0_f),
      .from_next(r1), .out_t(c1_t), .out_f(c1_f), .to_prev(r0));
   ncl_hs_reg #(.WIDTH(W)) u_s1 (.clk(clk), .rst_n(rst_n), .in_t(c1_t), .in_f(c1_f),
      .from_next(r2), .out_t(c2_t), .out_f(c2_f), .to_prev(r1));
   ncl_hs_reg #(.WIDTH(W)) u_s2 (.clk(clk), .rst_n(rst_n), .in_t(c2_t), .in_f(c2_f),
      .from_next(c_fn), .out_t(c3_t), .out_f(c3_f), .to_prev(r2));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input logic [W-1:0] t, input logic [W-1:0] f, input logic fn);
      in_t = t; in_f = f; from_next = fn;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      drive('0, '0, 1'b1);
      c0_t = '0; c0_f = '0; c_fn = 1'b1;
      tick(3);
      chk(d_out_t == '0 && d_out_f == '0, "R1", "outputs empty", {d_out_t, d_out_f}, 0);
      chk(d_req == 1'b1 && g_req == 1'b1, "R1", "request DATA", {d_req, g_req}, 3);
      rst_n = 1'b1;
      tick();
      chk(d_out_t == '0 && d_req == 1'b1, "R1", "state after release", {d_out_t, d_req}, 1);
   endtask

   task automatic t_data_wave();
      drive(8'hA5, 8'h5A, 1'b1);
      tick();
      chk(d_out_t == 8'hA5 && d_out_f == 8'h5A, "R2", "DATA latched", {d_out_t, d_out_f}, 16'hA55A);
      chk(d_req == 1'b1, "R5", "request not yet low", d_req, 1);
      tick();
      chk(d_req == 1'b0, "R5", "request low after full DATA", d_req, 0);
      chk(g_req == 1'b1, "R9", "grouped request one tick later", g_req, 1);
      tick();
      chk(g_req == 1'b0, "R9", "grouped request low", g_req, 0);
   endtask

   task automatic t_hold_release();
      drive(8'hA5, 8'h5A, 1'b0);
      tick();
      chk(d_out_t == 8'hA5 && d_out_f == 8'h5A, "R4", "DATA held, input DATA", {d_out_t, d_out_f}, 16'hA55A);
      drive('0, '0, 1'b1);
      tick(2);
      chk(d_out_t == 8'hA5 && d_out_f == 8'h5A, "R4", "DATA held, input NULL", {d_out_t, d_out_f}, 16'hA55A);
      chk(d_req == 1'b0, "R4", "request stays low", d_req, 0);
      drive(8'hA0, 8'h50, 1'b0);
      tick();
      chk(d_out_t == 8'hA0 && d_out_f == 8'h50, "R3", "low nibble emptied", {d_out_t, d_out_f}, 16'hA050);
      tick(2);
      chk(d_req == 1'b0, "R6", "partial NULL keeps request low", d_req, 0);
      chk(g_req == 1'b0, "R9", "grouped: one empty group keeps low", g_req, 0);
      drive('0, '0, 1'b0);
      tick();
      chk(d_out_t == '0 && d_out_f == '0, "R3", "all emptied", {d_out_t, d_out_f}, 0);
      chk(d_req == 1'b0, "R6", "request not yet high", d_req, 0);
      tick();
      chk(d_req == 1'b1, "R6", "request high after full NULL", d_req, 1);
      chk(g_req == 1'b0, "R9", "grouped still low", g_req, 0);
      tick();
      chk(g_req == 1'b1, "R9", "grouped request high", g_req, 1);
   endtask

   task automatic t_gated_data();
      drive(8'h5A, 8'hA5, 1'b0);
      tick(2);
      chk(d_out_t == '0 && d_out_f == '0, "R4", "DATA blocked by NULL request", {d_out_t, d_out_f}, 0);
      chk(d_req == 1'b1, "R4", "request unchanged", d_req, 1);
      from_next = 1'b1;
      tick();
      chk(d_out_t == 8'h5A && d_out_f == 8'hA5, "R2", "DATA admitted", {d_out_t, d_out_f}, 16'h5AA5);
      tick();
      drive('0, '0, 1'b0);
      tick(3);
      chk(d_out_t == '0 && d_req == 1'b1 && g_req == 1'b1, "R3", "return to NULL", {d_out_t, d_req, g_req}, 3);
   endtask

   task automatic t_partial_data();
      drive(8'h0C, 8'h03, 1'b1);
      tick(3);
      chk(d_out_t == 8'h0C && d_out_f == 8'h03, "R2", "partial DATA latched", {d_out_t, d_out_f}, 16'h0C03);
      chk(d_req == 1'b1, "R5", "partial DATA keeps request high", d_req, 1);
      chk(g_req == 1'b1, "R9", "grouped: one full group keeps high", g_req, 1);
      drive(8'h3C, 8'hC3, 1'b1);
      tick();
      chk(d_out_t == 8'h3C && d_out_f == 8'hC3, "R2", "full DATA", {d_out_t, d_out_f}, 16'h3CC3);
      tick();
      chk(d_req == 1'b0, "R5", "request low", d_req, 0);
      tick();
      chk(g_req == 1'b0, "R9", "grouped request low", g_req, 0);
      drive('0, '0, 1'b0);
      tick(3);
      from_next = 1'b1;
      tick();
   endtask

   function automatic logic [W-1:0] tok_val(input int k);
      return W'((k * 73 + 29) ^ (k << 3));
   endfunction

   always @(negedge clk) begin
      if (chain_on) begin
         for (int b = 0; b < W; b++) begin
            if ((c3_t[b] && c3_f[b]) || (c1_t[b] && c1_f[b])) swaps++;
         end
      end
   end

   logic [W-1:0] p1_t, p1_f, p3_t, p3_f;
   always @(negedge clk) begin
      if (chain_on) begin
         if ((p3_t & c3_f) != '0 || (p3_f & c3_t) != '0) swaps++;
         if ((p1_t & c1_f) != '0 || (p1_f & c1_t) != '0) swaps++;
      end
      p1_t <= c1_t; p1_f <= c1_f; p3_t <= c3_t; p3_f <= c3_f;
   end

   task automatic t_chain();
      int got = 0;
      int bad = 0;
      chain_on = 1'b1;
      fork
         begin
            for (int k = 0; k < NTOK; k++) begin
               while (r0 != 1'b1) tick();
               tick(int'($urandom_range(3, 0)));
               c0_t = tok_val(k); c0_f = ~tok_val(k);
               while (r0 != 1'b0) tick();
               tick(int'($urandom_range(3, 0)));
               c0_t = '0; c0_f = '0;
            end
         end
         begin
            for (int k = 0; k < NTOK; k++) begin
               while ((c3_t | c3_f) != {W{1'b1}}) tick();
               if (c3_t != tok_val(k) || c3_f != ~tok_val(k)) begin
                  bad++;
                  $display("FAIL R8 token %0d actual=%0h expected=%0h", k, c3_t, tok_val(k));
               end
               got++;
               tick(int'($urandom_range(4, 0)));
               c_fn = 1'b0;
               while ((c3_t | c3_f) != '0) tick();
               tick(int'($urandom_range(4, 0)));
               c_fn = 1'b1;
            end
         end
      join
      tick(4);
      chain_on = 1'b0;
      checks++;
      if (bad != 0) failures++;
      chk(got == NTOK, "R8", "tokens received", got, NTOK);
      chk(swaps == 0, "R7", "DATA overwrite events", swaps, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL R8 watchdog expired actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_data_wave();
      t_hold_release();
      t_gated_data();
      t_partial_data();
      t_chain();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule